// File: doc/BRIEF.md
# Lazy Flag Condition Evaluator

This block rebuilds the six arithmetic status flags of a byte/word/doubleword integer datapath on demand. It does not compute them in the cycle of the arithmetic operation. When an operation completes, the execution unit pulses a capture strobe. With it come the two operands, the addend-form sum, the result, a size code and a mask naming the flags that the operation affects. The block stores these in registers.

From the stored record the block derives carry, parity, adjust, zero, sign and overflow with bitwise formulas. For each flag a mask bit chooses between the derived value and the matching bit of an architectural flags word that arrives as a live input. From the six resulting flags, a 4-bit selector picks one of sixteen branch and set conditions.

For subtraction, the execution unit records the difference as the first operand, the subtrahend as the second operand and the minuend as the sum. The same formulas then give borrow and signed overflow. Instruction decode and the writeback of the flags register belong to other blocks.

Top module: `lazy_flag_eval`

## Requirements
- R1: While reset is high and after it, until the first capture, the saved mask is empty and every flag output equals its bit of the flags word. The bit order in both the flags word and the mask is 0 carry, 1 parity, 2 adjust, 3 zero, 4 sign, 5 overflow.
- R2: Operands, sum, result, size and mask load only on a clock edge where the capture strobe is high. Outputs show the new record from the cycle after that edge and hold it while the strobe stays low.
- R3: Each flag output takes its derived value when its saved mask bit is 1, and otherwise the same-numbered bit of the live flags word.
- R4: A size code of 7 or 15 selects the sign bit at that index. Any other code selects bit 31.
- R5: Carry is the sign-bit position of op1 ^ ((op1 ^ op2) & (op2 ^ sum)). This is the carry out for an addition and the borrow for a subtraction.
- R6: Overflow is the sign-bit position of (op1 ^ sum) & (op2 ^ sum).
- R7: Adjust is bit 4 of op1 ^ op2 ^ sum.
- R8: Zero is 1 exactly when result bits 0 up to the sign bit are all 0. Higher bits are ignored.
- R9: Parity is 1 when the low byte of the result has an even number of ones. Bits above 7 are ignored.
- R10: Sign is the result bit at the sign-bit position.
- R11: Condition index order: 0 OF, 2 CF, 4 ZF, 6 CF|ZF, 8 SF, 10 PF, 12 SF!=OF, 14 ZF|(SF!=OF).
- R12: Each odd index gives the inverse of the even index just below it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_valid | input | 1 | Capture strobe for a new operation record |
| cap_op1 | input | 32 | First operand (difference for subtraction) |
| cap_op2 | input | 32 | Second operand |
| cap_sum | input | 32 | Addend-form sum (minuend for subtraction) |
| cap_res | input | 32 | Operation result |
| cap_size | input | 5 | Sign-bit index: 7, 15, otherwise 31 |
| cap_dirty | input | 6 | Mask of flags to derive |
| flags_word | input | 6 | Stored architectural flags |
| cond_sel | input | 4 | Condition index |
| flag_cf | output | 1 | Carry |
| flag_pf | output | 1 | Parity |
| flag_af | output | 1 | Adjust |
| flag_zf | output | 1 | Zero |
| flag_sf | output | 1 | Sign |
| flag_of | output | 1 | Overflow |
| cond_true | output | 1 | Selected condition result |

## Verification
A new capture and the evaluation of the previous record can fall in the same cycle. In that cycle the outputs must still describe the older record, even though fresh operands are already at the inputs. The bench holds one record, then raises the strobe with a different operation and a different flags word. It samples before the edge and expects the old flags, then samples after the edge and expects the new ones. It then leaves the strobe low with changed inputs and expects no movement. Separately, the flags word is changed under partial masks to show that clean flags track it live while derived ones do not.

// File: rtl/lfe_pkg.sv
`timescale 1ns/100ps
package lfe_pkg;

    localparam int DATA_W  = 32;
    localparam int NFLAG   = 6;
    localparam int COND_W  = 4;
    localparam int SIZE_W  = 5;
    localparam int AF_BIT  = 4;
    localparam int BYTE_SB = 7;
    localparam int WORD_SB = 15;
    localparam int DWRD_SB = DATA_W - 1;
    localparam logic [15:0] PAR_LUT = 16'h9669;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2
    } size_e;

    // packed with carry in bit 0, overflow in bit 5
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic adj;
        logic par;
        logic cry;
    } flags_t;

    typedef enum logic [COND_W-1:0] {
        CC_O = 4'h0, CC_NO = 4'h1, CC_B = 4'h2, CC_NB = 4'h3,
        CC_Z = 4'h4, CC_NZ = 4'h5, CC_BE = 4'h6, CC_NBE = 4'h7,
        CC_S = 4'h8, CC_NS = 4'h9, CC_P = 4'hA, CC_NP = 4'hB,
        CC_L = 4'hC, CC_NL = 4'hD, CC_LE = 4'hE, CC_NLE = 4'hF
    } cond_e;

    typedef struct packed {
        logic [DATA_W-1:0] op1;
        logic [DATA_W-1:0] op2;
        logic [DATA_W-1:0] sum;
        logic [DATA_W-1:0] res;
        size_e             sz;
        flags_t            dirty;
    } op_rec_t;

    function automatic size_e decode_size(input logic [SIZE_W-1:0] code);
        if (code == SIZE_W'(BYTE_SB))      return SZ_BYTE;
        else if (code == SIZE_W'(WORD_SB)) return SZ_WORD;
        else                               return SZ_DWORD;
    endfunction

    function automatic logic sign_bit(input logic [DATA_W-1:0] v, input size_e sz);
        case (sz)
            SZ_BYTE: return v[BYTE_SB];
            SZ_WORD: return v[WORD_SB];
            default: return v[DWRD_SB];
        endcase
    endfunction

    function automatic logic even_parity(input logic [7:0] b);
        logic [3:0] nib;
        nib = b[7:4] ^ b[3:0];
        return PAR_LUT[nib];
    endfunction

endpackage

// File: rtl/lfe_capture.sv
`timescale 1ns/100ps
module lfe_capture
    import lfe_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  op_rec_t rec_in,
    output op_rec_t rec_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q.op1   <= '0;
            rec_q.op2   <= '0;
            rec_q.sum   <= '0;
            rec_q.res   <= '0;
            rec_q.sz    <= SZ_DWORD;
            rec_q.dirty <= '0;
        end else if (load) begin
            rec_q <= rec_in;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(rec_q)); // R2

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        load |=> (rec_q.res == $past(rec_in.res) && rec_q.dirty == $past(rec_in.dirty))); // R2

endmodule

// File: rtl/lfe_flag_calc.sv
`timescale 1ns/100ps
module lfe_flag_calc
    import lfe_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  op_rec_t rec,
    input  flags_t  word,
    output flags_t  flags
);

    logic [DATA_W-1:0] carry_vec;
    logic [DATA_W-1:0] ovf_vec;
    logic [DATA_W-1:0] half_vec;
    logic [DATA_W-1:0] zero_vec;
    flags_t            derived;

    always_comb begin
        carry_vec   = rec.op1 ^ ((rec.op1 ^ rec.op2) & (rec.op2 ^ rec.sum));
        ovf_vec     = (rec.op1 ^ rec.sum) & (rec.op2 ^ rec.sum);
        half_vec    = rec.op1 ^ rec.op2 ^ rec.sum;
        zero_vec    = ~rec.res & (rec.res - DATA_W'(1));
        derived.cry = sign_bit(carry_vec, rec.sz);
        derived.ovf = sign_bit(ovf_vec, rec.sz);
        derived.adj = half_vec[AF_BIT];
        derived.zro = sign_bit(zero_vec, rec.sz);
        derived.sgn = sign_bit(rec.res, rec.sz);
        derived.par = even_parity(rec.res[7:0]);
    end

    logic [NFLAG-1:0] dmask, dval, wval, outv;
    assign dmask = rec.dirty;
    assign dval  = derived;
    assign wval  = word;

    for (genvar i = 0; i < NFLAG; i++) begin : g_sel
        assign outv[i] = dmask[i] ? dval[i] : wval[i];
    end

    assign flags = outv;

    AST_ZERO_NOT_NEG: assert property (@(posedge clk) disable iff (rst)
        derived.zro |-> !derived.sgn); // R8

    AST_CLEAN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (rec.dirty == '0) |-> (flags == word)); // R3

endmodule

// File: rtl/lfe_cond_eval.sv
`timescale 1ns/100ps
module lfe_cond_eval
    import lfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  flags_t            f,
    input  logic [COND_W-1:0] sel,
    output logic              hit
);

    localparam int NBASE = 1 << (COND_W - 1);

    logic [NBASE-1:0] base;

    always_comb begin
        base[0] = f.ovf;
        base[1] = f.cry;
        base[2] = f.zro;
        base[3] = f.cry | f.zro;
        base[4] = f.sgn;
        base[5] = f.par;
        base[6] = f.sgn ^ f.ovf;
        base[7] = f.zro | (f.sgn ^ f.ovf);
    end

    assign hit = base[sel[COND_W-1:1]] ^ sel[0];

    AST_LE_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
        (sel == CC_LE && f.zro) |-> hit); // R11

    AST_NB_ON_CARRY: assert property (@(posedge clk) disable iff (rst)
        (sel == CC_NB && f.cry) |-> !hit); // R12

endmodule

// File: rtl/lazy_flag_eval.sv
`timescale 1ns/100ps
module lazy_flag_eval
    import lfe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cap_valid,
    input  logic [31:0] cap_op1,
    input  logic [31:0] cap_op2,
    input  logic [31:0] cap_sum,
    input  logic [31:0] cap_res,
    input  logic [4:0]  cap_size,
    input  logic [5:0]  cap_dirty,
    input  logic [5:0]  flags_word,
    input  logic [3:0]  cond_sel,
    output logic        flag_cf,
    output logic        flag_pf,
    output logic        flag_af,
    output logic        flag_zf,
    output logic        flag_sf,
    output logic        flag_of,
    output logic        cond_true
);

    op_rec_t rec_in, rec_q;
    flags_t  word, flags;

    always_comb begin
        rec_in.op1   = cap_op1;
        rec_in.op2   = cap_op2;
        rec_in.sum   = cap_sum;
        rec_in.res   = cap_res;
        rec_in.sz    = decode_size(cap_size);
        rec_in.dirty = cap_dirty;
    end

    assign word = flags_word;

    lfe_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .load   (cap_valid),
        .rec_in (rec_in),
        .rec_q  (rec_q)
    );

    lfe_flag_calc u_calc (
        .clk   (clk),
        .rst   (rst),
        .rec   (rec_q),
        .word  (word),
        .flags (flags)
    );

    lfe_cond_eval u_cond (
        .clk (clk),
        .rst (rst),
        .f   (flags),
        .sel (cond_sel),
        .hit (cond_true)
    );

    assign flag_cf = flags.cry;
    assign flag_pf = flags.par;
    assign flag_af = flags.adj;
    assign flag_zf = flags.zro;
    assign flag_sf = flags.sgn;
    assign flag_of = flags.ovf;

    AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        rec_q.sz != 2'd3); // R4

endmodule

// File: tb/lazy_flag_eval_tb.sv
`timescale 1ns/100ps
module lazy_flag_eval_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_valid = 1'b0;
    logic [31:0] cap_op1 = '0, cap_op2 = '0, cap_sum = '0, cap_res = '0;
    logic [4:0]  cap_size = 5'd31;
    logic [5:0]  cap_dirty = '0;
    logic [5:0]  flags_word = '0;
    logic [3:0]  cond_sel = '0;
    logic flag_cf, flag_pf, flag_af, flag_zf, flag_sf, flag_of, cond_true;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    lazy_flag_eval u_dut (
        .clk(clk), .rst(rst), .cap_valid(cap_valid),
        .cap_op1(cap_op1), .cap_op2(cap_op2), .cap_sum(cap_sum), .cap_res(cap_res),
        .cap_size(cap_size), .cap_dirty(cap_dirty), .flags_word(flags_word),
        .cond_sel(cond_sel), .flag_cf(flag_cf), .flag_pf(flag_pf), .flag_af(flag_af),
        .flag_zf(flag_zf), .flag_sf(flag_sf), .flag_of(flag_of), .cond_true(cond_true)
    );

    // {sub, size code, a, b}
    localparam logic [69:0] VEC [16] = '{
        {1'b0, 5'd7,  32'h0000_00FF, 32'h0000_0001},
        {1'b0, 5'd7,  32'h0000_007F, 32'h0000_0001},
        {1'b1, 5'd7,  32'h0000_0000, 32'h0000_0001},
        {1'b1, 5'd7,  32'h0000_0080, 32'h0000_0001},
        {1'b0, 5'd15, 32'h0000_FFFF, 32'h0000_0001},
        {1'b0, 5'd15, 32'h0000_7FFF, 32'h0000_7FFF},
        {1'b1, 5'd15, 32'h0000_1234, 32'h0000_1234},
        {1'b1, 5'd15, 32'hABCD_8000, 32'h1234_0001},
        {1'b0, 5'd31, 32'hFFFF_FFFF, 32'h0000_0001},
        {1'b0, 5'd31, 32'h7FFF_FFFF, 32'h0000_0001},
        {1'b1, 5'd31, 32'h8000_0000, 32'h0000_0001},
        {1'b1, 5'd31, 32'h0000_0005, 32'h0000_0009},
        {1'b0, 5'd31, 32'h0000_000F, 32'h0000_0001},
        {1'b0, 5'd7,  32'hFFFF_FF08, 32'h0000_0008},
        {1'b1, 5'd31, 32'h1234_5678, 32'h1234_5678},
        {1'b0, 5'd15, 32'h0000_8000, 32'h0000_8000}
    };

    // returns {of,sf,zf,af,pf,cf}
    function automatic logic [5:0] ref_flags(input logic sub, input logic [4:0] code,
                                             input logic [31:0] a, input logic [31:0] b);
        int w;
        logic [31:0] m, am, bm, r;
        logic [32:0] wide;
        logic cf, af, zf, sf, pf, of;
        w  = (code == 5'd7) ? 8 : (code == 5'd15) ? 16 : 32;
        m  = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
        am = a & m;
        bm = b & m;
        wide = {1'b0, am} + {1'b0, bm};
        r  = sub ? ((am - bm) & m) : (wide[31:0] & m);
        cf = sub ? (am < bm) : wide[w];
        af = sub ? (a[3:0] < b[3:0]) : (({1'b0, a[3:0]} + {1'b0, b[3:0]}) > 5'd15);
        zf = (r == 0);
        sf = r[w-1];
        pf = ~^r[7:0];
        of = sub ? ((am[w-1] != bm[w-1]) && (r[w-1] != am[w-1]))
                 : ((am[w-1] == bm[w-1]) && (r[w-1] != am[w-1]));
        return {of, sf, zf, af, pf, cf};
    endfunction

    function automatic logic ref_cond(input logic [3:0] s, input logic [5:0] f);
        logic cf, zf, sf, of, pf;
        {of, sf, zf} = f[5:3];
        pf = f[1];
        cf = f[0];
        case (s)
            4'h0: return of;          4'h1: return !of;
            4'h2: return cf;          4'h3: return !cf;
            4'h4: return zf;          4'h5: return !zf;
            4'h6: return cf | zf;     4'h7: return !(cf | zf);
            4'h8: return sf;          4'h9: return !sf;
            4'hA: return pf;          4'hB: return !pf;
            4'hC: return sf != of;    4'hD: return sf == of;
            4'hE: return zf | (sf != of);
            default: return !(zf | (sf != of));
        endcase
    endfunction

    function automatic logic [5:0] outs();
        return {flag_of, flag_sf, flag_zf, flag_af, flag_pf, flag_cf};
    endfunction

    task automatic check6(input string req, input logic [5:0] exp);
        n_tests++;
        if (outs() !== exp) begin
            n_fail++;
            $display("FAIL %s flags actual=%b expected=%b", req, outs(), exp);
        end
    endtask

    task automatic put(input logic sub, input logic [4:0] code, input logic [31:0] a,
                       input logic [31:0] b, input logic [5:0] mask);
        cap_size  = code;
        cap_dirty = mask;
        if (sub) begin
            cap_op1 = a - b; cap_op2 = b; cap_sum = a; cap_res = a - b;
        end else begin
            cap_op1 = a; cap_op2 = b; cap_sum = a + b; cap_res = a + b;
        end
    endtask

    task automatic capture(input logic sub, input logic [4:0] code, input logic [31:0] a,
                           input logic [31:0] b, input logic [5:0] mask);
        @(negedge clk);
        put(sub, code, a, b, mask);
        cap_valid = 1'b1;
        @(negedge clk);
        cap_valid = 1'b0;
        #0.5;
    endtask

    task automatic sweep_conds(input logic [5:0] f);
        for (int s = 0; s < 16; s++) begin
            cond_sel = 4'(s);
            #0.1;
            n_tests++;
            if (cond_true !== ref_cond(4'(s), f)) begin
                n_fail++;
                $display("FAIL R11/R12 sel=%0d actual=%b expected=%b", s, cond_true,
                         ref_cond(4'(s), f));
            end
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        logic [5:0]  ea, eb, p;
        seed = 32'h1BAD_5EED;

        // R1: reset state follows flags word
        flags_word = 6'b101010;
        repeat (3) @(negedge clk);
        #0.5;
        check6("R1 during reset", 6'b101010);
        rst = 1'b0;
        @(negedge clk);
        flags_word = 6'b010101;
        #0.5;
        check6("R1 after reset", 6'b010101);

        // table walk: R5 R6 R7 R8 R9 R10, then conditions R11 R12
        for (int i = 0; i < 16; i++) begin
            capture(VEC[i][69], VEC[i][68:64], VEC[i][63:32], VEC[i][31:0], 6'h3F);
            ea = ref_flags(VEC[i][69], VEC[i][68:64], VEC[i][63:32], VEC[i][31:0]);
            check6($sformatf("R5/R6/R7/R8/R9/R10 vec%0d", i), ea);
            sweep_conds(ea);
        end

        // random add/sub over the three sizes
        for (int i = 0; i < 300; i++) begin
            logic [31:0] a, b;
            logic [4:0]  code;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            a = seed;
            seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
            b = seed;
            code = (i % 3 == 0) ? 5'd7 : (i % 3 == 1) ? 5'd15 : 5'd31;
            capture(seed[3], code, a, b, 6'h3F);
            check6($sformatf("R5/R6/R7/R10 rand%0d", i), ref_flags(seed[3], code, a, b));
        end

        // R3: per-flag mask selection with live word
        p = ref_flags(1'b1, 5'd31, 32'h0000_0005, 32'h0000_0009);
        for (int k = 0; k < 6; k++) begin
            logic [5:0] m;
            m = 6'(1 << k) | 6'b000100;
            capture(1'b1, 5'd31, 32'h0000_0005, 32'h0000_0009, m);
            flags_word = ~p;
            #0.5;
            check6($sformatf("R3 mask=%b", m), (p & m) | (~p & ~m));
            flags_word = p ^ 6'b110011;
            #0.5;
            check6("R3 live word", (p & m) | ((p ^ 6'b110011) & ~m));
        end

        // R4: unsupported size code acts as 31
        flags_word = '0;
        capture(1'b0, 5'd3, 32'h7FFF_FFFF, 32'h0000_0001, 6'h3F);
        check6("R4 code3 as 31", ref_flags(1'b0, 5'd31, 32'h7FFF_FFFF, 32'h0000_0001));
        capture(1'b0, 5'd15, 32'h0000_7FFF, 32'h0000_0001, 6'h3F);
        check6("R4 code15", ref_flags(1'b0, 5'd15, 32'h0000_7FFF, 32'h0000_0001));

        // R8 / R9 with junk above the active size
        @(negedge clk);
        cap_op1 = '0; cap_op2 = '0; cap_sum = '0; cap_res = 32'hFFFF_FF00;
        cap_size = 5'd7; cap_dirty = 6'h3F; cap_valid = 1'b1;
        @(negedge clk); cap_valid = 1'b0; #0.5;
        check6("R8/R9 byte zero with high junk", 6'b001010);
        @(negedge clk);
        cap_res = 32'hFF00_0001; cap_size = 5'd31; cap_valid = 1'b1;
        @(negedge clk); cap_valid = 1'b0; #0.5;
        check6("R9/R10 odd low byte", 6'b010000);

        // R2: capture and evaluation in the same cycle
        capture(1'b0, 5'd7, 32'h0000_00FF, 32'h0000_0001, 6'h3F);
        ea = ref_flags(1'b0, 5'd7, 32'h0000_00FF, 32'h0000_0001);
        eb = ref_flags(1'b1, 5'd31, 32'h8000_0000, 32'h0000_0001);
        @(negedge clk);
        put(1'b1, 5'd31, 32'h8000_0000, 32'h0000_0001, 6'h3F);
        flags_word = 6'h3F;
        cap_valid = 1'b1;
        #0.5;
        check6("R2 before edge keeps old", ea);
        @(negedge clk);
        cap_valid = 1'b0;
        #0.5;
        check6("R2 after edge shows new", eb);
        put(1'b0, 5'd7, 32'h0000_0001, 32'h0000_0001, 6'h00);
        repeat (2) @(negedge clk);
        #0.5;
        check6("R2 hold without strobe", eb);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule